// File: doc/BRIEF.md
# Bit-Addressable Internal Data Store

This block holds the 256-byte internal data space of an 8-bit microcontroller core. The lower half is working RAM and the upper half holds the special-function registers. It has two request ports. The byte port reads and writes whole bytes. It accepts a direct address, which always lands in the local array, or an indirect address. An indirect address in the upper half leaves the block on a simple external-memory request interface. The bit port reads or writes one bit, named by an 8-bit bit address.

The bit port maps its bit address onto a byte as follows. Bit addresses from 0x00 to 0x7F cover the sixteen RAM bytes that start at 0x20. Bit addresses from 0x80 to 0xFF fall on the register bytes whose addresses are multiples of eight. A bit write is a two-cycle read-modify-write. The port is not ready during the second cycle, which is the merge cycle.

Reset is synchronous. It loads every byte with zero, except the four port registers, which load all ones, and the stack pointer, which loads 0x07.

Top module: `iram_bitstore`

## Requirements
- R1: While rst is high and on the first cycle after it, every byte reads 0x00. The exceptions are 0x80, 0x90, 0xA0 and 0xB0, which read 0xFF, and 0x81, which reads 0x07. After reset, bit_ready is 1 and bit_busy is 0.
- R2: A direct byte request (byte_ind=0) reaches any address from 0x00 to 0xFF in the local array. A read presents byte_rvalid=1 and byte_rdata on the cycle after the request is taken.
- R3: An indirect byte request (byte_ind=1) with an address of 0x7F or below uses the same local byte as a direct request, and ext_req stays 0.
- R4: An indirect byte request with an address of 0x80 or above drives ext_req=1 in the same cycle, with ext_we, ext_addr and ext_wdata copied from the request. Such a write leaves the local byte at that address unchanged. Such a read returns, on the next cycle, the ext_rdata that the external memory presents in that cycle.
- R5: A bit address below 0x80 selects byte 0x20 + (bit_addr >> 3), bit position bit_addr[2:0].
- R6: A bit address of 0x80 or above selects byte {bit_addr[7:3], 3'b000}, bit position bit_addr[2:0].
- R7: A bit write stores bit_wval[0] at the selected position and leaves the other seven bits alone. After the write is accepted, bit_busy is 1 and bit_ready is 0 for exactly one cycle. A bit request that is held during that cycle is accepted on the following cycle.
- R8: A bit read presents bit_rvalid=1 on the next cycle, and bit_rdata holds the selected bit as it stood before that clock edge.
- R9: If an internal byte write hits the same byte in the cycle where a bit write merges, the byte write's data is what remains.
- R10: If an internal byte write hits the target byte in the cycle where a bit write is accepted, the merge is built on the byte write's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Byte request present (always taken) |
| byte_we | input | 1 | 1 = write, 0 = read |
| byte_ind | input | 1 | 1 = indirect address, 0 = direct |
| byte_addr | input | 8 | Byte address |
| byte_wdata | input | 8 | Byte write data |
| byte_rvalid | output | 1 | Byte read data valid |
| byte_rdata | output | 8 | Byte read data |
| bit_valid | input | 1 | Bit request present |
| bit_we | input | 1 | 1 = bit write, 0 = bit read |
| bit_addr | input | 8 | Bit address |
| bit_wval | input | 1 | Value to store |
| bit_ready | output | 1 | Bit port can take a request |
| bit_busy | output | 1 | Bit write in its merge cycle |
| bit_rvalid | output | 1 | Bit read result valid |
| bit_rdata | output | 1 | Bit read result |
| ext_req | output | 1 | External memory request |
| ext_we | output | 1 | External write strobe |
| ext_addr | output | 8 | External address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, valid the cycle after ext_req |

## Verification
On every cycle, the assertions check the following:
- a bit write disturbs at most one bit of its byte;
- a colliding byte write wins;
- busy lasts exactly one cycle after a write is accepted;
- upper-half indirect requests go to the external port and never write locally;
- a read answers one cycle later.

Only the bench's scenarios can show the rest. That covers the reset contents, the two bit-address maps, forwarding of a byte write made in the capture cycle, the hold-off of a request made while busy, and the external read data path. The bench shows these by comparing readback against a model of the whole data space under random and directed sequences.

// File: rtl/iram_pkg.sv
package iram_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned POS_W    = $clog2(BYTE_W);
    localparam int unsigned DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] BIT_RAM_BASE = 8'h20;
    localparam logic [ADDR_W-1:0] UPPER_START  = 8'h80;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef enum logic {
        BS_IDLE  = 1'b0,
        BS_MERGE = 1'b1
    } bit_state_e;

    typedef struct packed {
        addr_t byte_addr;
        pos_t  pos;
    } bit_loc_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_port_t;

    // Map a bit address onto its containing byte and position.
    function automatic bit_loc_t locate_bit(addr_t a);
        bit_loc_t r;
        r.pos = a[POS_W-1:0];
        if (a >= UPPER_START)
            r.byte_addr = {a[ADDR_W-1:POS_W], {POS_W{1'b0}}};
        else
            r.byte_addr = BIT_RAM_BASE + addr_t'(a >> POS_W);
        return r;
    endfunction

    // Replace one bit of a byte.
    function automatic byte_t insert_bit(byte_t b, pos_t pos, logic v);
        byte_t r;
        r      = b;
        r[pos] = v;
        return r;
    endfunction

    // Power-on contents of one byte.
    function automatic byte_t reset_byte(addr_t a);
        case (a)
            8'h80, 8'h90, 8'hA0, 8'hB0: return 8'hFF;
            8'h81:                      return 8'h07;
            default:                    return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/iram_bit_map.sv
module iram_bit_map
    import iram_pkg::*;
(
    input  addr_t    bit_addr,
    output bit_loc_t loc
);
    always_comb loc = locate_bit(bit_addr);
endmodule

// File: rtl/iram_byte_route.sv
module iram_byte_route
    import iram_pkg::*;
(
    input  logic     byte_valid,
    input  logic     byte_we,
    input  logic     byte_ind,
    input  addr_t    byte_addr,
    input  byte_t    byte_wdata,
    output logic     to_ext,
    output wr_port_t int_wr,
    output logic     ext_req,
    output logic     ext_we,
    output addr_t    ext_addr,
    output byte_t    ext_wdata
);
    always_comb begin
        to_ext      = byte_ind && (byte_addr >= UPPER_START);
        int_wr.en   = byte_valid && byte_we && !to_ext;
        int_wr.addr = byte_addr;
        int_wr.data = byte_wdata;
        ext_req     = byte_valid && to_ext;
        ext_we      = byte_we;
        ext_addr    = byte_addr;
        ext_wdata   = byte_wdata;
    end
endmodule

// File: rtl/iram_array.sv
module iram_array
    import iram_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  addr_t    rd_a_addr,
    output byte_t    rd_a_data,
    input  addr_t    rd_b_addr,
    output byte_t    rd_b_data,
    input  wr_port_t wr_a,      // byte port, higher priority
    input  wr_port_t wr_b       // bit merge port
);
    byte_t mem_q [DEPTH];
    byte_t b_old;

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst)
                mem_q[i] <= reset_byte(addr_t'(i));
            else if (wr_a.en && wr_a.addr == addr_t'(i))
                mem_q[i] <= wr_a.data;
            else if (wr_b.en && wr_b.addr == addr_t'(i))
                mem_q[i] <= wr_b.data;
        end
    end

    always_comb begin
        rd_a_data = mem_q[rd_a_addr];
        rd_b_data = mem_q[rd_b_addr];
        b_old     = mem_q[wr_b.addr];
    end

    p_byte_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_a.en && wr_b.en && wr_a.addr == wr_b.addr)
        |=> mem_q[$past(wr_a.addr)] == $past(wr_a.data));

    p_bit_isolated_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_b.en && !(wr_a.en && wr_a.addr == wr_b.addr))
        |=> $countones(mem_q[$past(wr_b.addr)] ^ $past(b_old)) <= 1);
endmodule

// File: rtl/iram_bit_engine.sv
module iram_bit_engine
    import iram_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_valid,
    input  logic     bit_we,
    input  addr_t    bit_addr,
    input  logic     bit_wval,
    input  wr_port_t fwd_wr,     // same-cycle byte write for forwarding
    output addr_t    rd_addr,
    input  byte_t    rd_data,
    output wr_port_t merge_wr,
    output logic     bit_ready,
    output logic     busy,
    output logic     bit_rvalid,
    output logic     bit_rdata
);
    bit_state_e state_q;
    bit_loc_t   loc_now;
    addr_t      tgt_q;
    byte_t      hold_q;
    byte_t      seen;
    logic       accept;
    logic       rvalid_q;
    logic       rbit_q;

    iram_bit_map u_map (
        .bit_addr (bit_addr),
        .loc      (loc_now)
    );

    always_comb begin
        bit_ready = (state_q == BS_IDLE);
        busy      = (state_q == BS_MERGE);
        accept    = bit_valid && bit_ready;
        rd_addr   = loc_now.byte_addr;
        seen      = (fwd_wr.en && fwd_wr.addr == loc_now.byte_addr) ? fwd_wr.data : rd_data;
        merge_wr.en   = busy;
        merge_wr.addr = tgt_q;
        merge_wr.data = hold_q;
        bit_rvalid    = rvalid_q;
        bit_rdata     = rbit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BS_IDLE;
            tgt_q    <= '0;
            hold_q   <= '0;
            rvalid_q <= 1'b0;
            rbit_q   <= 1'b0;
        end else begin
            rvalid_q <= accept && !bit_we;
            if (accept && !bit_we)
                rbit_q <= rd_data[loc_now.pos];
            case (state_q)
                BS_IDLE: begin
                    if (accept && bit_we) begin
                        hold_q  <= insert_bit(seen, loc_now.pos, bit_wval);
                        tgt_q   <= loc_now.byte_addr;
                        state_q <= BS_MERGE;
                    end
                end
                default: state_q <= BS_IDLE;
            endcase
        end
    end

    p_busy_after_write_r7: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_ready && bit_we) |=> busy);

    p_busy_single_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
endmodule

// File: rtl/iram_bitstore.sv
module iram_bitstore
    import iram_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                byte_valid,
    input  logic                byte_we,
    input  logic                byte_ind,
    input  logic [ADDR_W-1:0]   byte_addr,
    input  logic [BYTE_W-1:0]   byte_wdata,
    output logic                byte_rvalid,
    output logic [BYTE_W-1:0]   byte_rdata,
    input  logic                bit_valid,
    input  logic                bit_we,
    input  logic [ADDR_W-1:0]   bit_addr,
    input  logic                bit_wval,
    output logic                bit_ready,
    output logic                bit_busy,
    output logic                bit_rvalid,
    output logic                bit_rdata,
    output logic                ext_req,
    output logic                ext_we,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic [BYTE_W-1:0]   ext_wdata,
    input  logic [BYTE_W-1:0]   ext_rdata
);
    logic     to_ext;
    wr_port_t int_wr;
    wr_port_t merge_wr;
    addr_t    bit_rd_addr;
    byte_t    bit_rd_data;
    byte_t    byte_rd_data;
    logic     rvalid_q;
    logic     from_ext_q;
    byte_t    local_q;

    iram_byte_route u_route (
        .byte_valid (byte_valid),
        .byte_we    (byte_we),
        .byte_ind   (byte_ind),
        .byte_addr  (byte_addr),
        .byte_wdata (byte_wdata),
        .to_ext     (to_ext),
        .int_wr     (int_wr),
        .ext_req    (ext_req),
        .ext_we     (ext_we),
        .ext_addr   (ext_addr),
        .ext_wdata  (ext_wdata)
    );

    iram_array u_array (
        .clk       (clk),
        .rst       (rst),
        .rd_a_addr (byte_addr),
        .rd_a_data (byte_rd_data),
        .rd_b_addr (bit_rd_addr),
        .rd_b_data (bit_rd_data),
        .wr_a      (int_wr),
        .wr_b      (merge_wr)
    );

    iram_bit_engine u_bit (
        .clk        (clk),
        .rst        (rst),
        .bit_valid  (bit_valid),
        .bit_we     (bit_we),
        .bit_addr   (bit_addr),
        .bit_wval   (bit_wval),
        .fwd_wr     (int_wr),
        .rd_addr    (bit_rd_addr),
        .rd_data    (bit_rd_data),
        .merge_wr   (merge_wr),
        .bit_ready  (bit_ready),
        .busy       (bit_busy),
        .bit_rvalid (bit_rvalid),
        .bit_rdata  (bit_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q   <= 1'b0;
            from_ext_q <= 1'b0;
            local_q    <= '0;
        end else begin
            rvalid_q   <= byte_valid && !byte_we;
            from_ext_q <= to_ext;
            if (byte_valid && !byte_we)
                local_q <= byte_rd_data;
        end
    end

    always_comb begin
        byte_rvalid = rvalid_q;
        byte_rdata  = from_ext_q ? ext_rdata : local_q;
    end

    p_upper_indirect_external_r4: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_ind && byte_addr[ADDR_W-1]) |-> (ext_req && !int_wr.en));

    p_read_answers_r2: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_we) |=> byte_rvalid);
endmodule

// File: tb/iram_bitstore_tb.sv
`timescale 1ns/1ps
module iram_bitstore_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_valid = 0, byte_we = 0, byte_ind = 0;
    logic [7:0] byte_addr = 0, byte_wdata = 0;
    logic       byte_rvalid;
    logic [7:0] byte_rdata;
    logic       bit_valid = 0, bit_we = 0, bit_wval = 0;
    logic [7:0] bit_addr = 0;
    logic       bit_ready, bit_busy, bit_rvalid, bit_rdata;
    logic       ext_req, ext_we;
    logic [7:0] ext_addr, ext_wdata;
    logic [7:0] ext_rdata = 0;

    logic [7:0] ext_mem [128];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ext [128];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    iram_bitstore u_dut (.*);

    // External memory stub: one-cycle read latency.
    always @(posedge clk) begin
        if (ext_req) begin
            if (ext_we) ext_mem[ext_addr[6:0]] <= ext_wdata;
            else        ext_rdata <= ext_mem[ext_addr[6:0]];
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] rst_val(int a);
        if (a == 'h80 || a == 'h90 || a == 'hA0 || a == 'hB0) return 8'hFF;
        if (a == 'h81) return 8'h07;
        return 8'h00;
    endfunction

    function automatic int byte_of(logic [7:0] ba);
        if (ba >= 8'h80) return int'(ba) / 8 * 8;
        return 'h20 + int'(ba) / 8;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // Byte request; caller stands just after a negedge.
    task automatic byte_op(string req, logic ind, logic we, logic [7:0] a, logic [7:0] d);
        logic up;
        logic [7:0] expd;
        up = ind && a[7];
        expd = up ? exp_ext[a[6:0]] : exp_mem[a];
        byte_valid = 1; byte_we = we; byte_ind = ind; byte_addr = a; byte_wdata = d;
        #1;
        if (up) begin
            chk("R4 ext_req", {15'd0, ext_req}, 16'd1);
            chk("R4 ext fields", {ext_we, ext_addr, ext_wdata[6:0]}, {we, a, d[6:0]});
        end else begin
            chk({req, " no ext_req"}, {15'd0, ext_req}, 16'd0);
        end
        @(posedge clk); @(negedge clk);
        byte_valid = 0; byte_we = 0; byte_ind = 0;
        if (!we) begin
            chk({req, " rvalid"}, {15'd0, byte_rvalid}, 16'd1);
            chk({req, " rdata"}, {8'd0, byte_rdata}, {8'd0, expd});
        end else if (up) begin
            exp_ext[a[6:0]] = d;
        end else begin
            exp_mem[a] = d;
        end
    endtask

    task automatic bit_wr(logic [7:0] ba, logic v);
        int b;
        b = byte_of(ba);
        bit_valid = 1; bit_we = 1; bit_addr = ba; bit_wval = v;
        @(posedge clk); @(negedge clk);
        bit_valid = 0; bit_we = 0;
        chk("R7 busy in merge", {14'd0, bit_busy, bit_ready}, 16'b10);
        @(posedge clk); @(negedge clk);
        chk("R7 busy released", {14'd0, bit_busy, bit_ready}, 16'b01);
        exp_mem[b][ba[2:0]] = v;
    endtask

    task automatic bit_rd(logic [7:0] ba);
        logic e;
        e = exp_mem[byte_of(ba)][ba[2:0]];
        bit_valid = 1; bit_we = 0; bit_addr = ba;
        @(posedge clk); @(negedge clk);
        bit_valid = 0;
        chk("R8 bit_rvalid", {15'd0, bit_rvalid}, 16'd1);
        chk(ba[7] ? "R6 bit read" : "R5 bit read", {15'd0, bit_rdata}, {15'd0, e});
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            ext_mem[i] = 8'(i ^ 'h5A);
            exp_ext[i] = 8'(i ^ 'h5A);
        end
        for (int i = 0; i < 256; i++) exp_mem[i] = rst_val(i);
        void'($urandom(32'd4242));

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready/busy in reset", {14'd0, bit_busy, bit_ready}, 16'b01);
        rst = 0;
        chk("R1 rvalid after reset", {14'd0, byte_rvalid, bit_rvalid}, 16'd0);

        // R1: full reset image.
        for (int i = 0; i < 256; i++) byte_op("R1", 1'b0, 1'b0, 8'(i), 8'h00);

        // R2 / R3 / R4 directed.
        byte_op("R2", 0, 1, 8'hFF, 8'hC3);
        byte_op("R2", 0, 0, 8'hFF, 8'h00);
        byte_op("R3", 1, 1, 8'h7F, 8'h3C);
        byte_op("R2", 0, 0, 8'h7F, 8'h00);
        byte_op("R4", 1, 1, 8'h90, 8'h12);
        byte_op("R4 local untouched", 0, 0, 8'h90, 8'h00);
        byte_op("R4", 1, 0, 8'h90, 8'h00);
        byte_op("R4", 1, 0, 8'h80, 8'h00);

        // R5 / R6 mapping via byte readback.
        bit_wr(8'h7F, 1);
        byte_op("R5 map 0x7F", 0, 0, 8'h2F, 8'h00);
        bit_wr(8'h00, 1);
        byte_op("R5 map 0x00", 0, 0, 8'h20, 8'h00);
        bit_wr(8'h87, 0);
        byte_op("R6 map 0x87", 0, 0, 8'h80, 8'h00);
        bit_wr(8'hE3, 1);
        byte_op("R6 map 0xE3", 0, 0, 8'hE0, 8'h00);
        bit_rd(8'h87);
        bit_rd(8'h86);

        // R7 hold-off: second request held through the busy cycle.
        bit_valid = 1; bit_we = 1; bit_addr = 8'h11; bit_wval = 1;
        @(posedge clk); @(negedge clk);
        bit_addr = 8'hF5; bit_wval = 1;
        chk("R7 not ready while busy", {15'd0, bit_ready}, 16'd0);
        @(posedge clk); @(negedge clk);
        chk("R7 ready after merge", {15'd0, bit_ready}, 16'd1);
        @(posedge clk); @(negedge clk);
        bit_valid = 0; bit_we = 0;
        chk("R7 held request taken", {15'd0, bit_busy}, 16'd1);
        @(posedge clk); @(negedge clk);
        exp_mem[8'h22][1] = 1'b1;
        exp_mem[8'hF0][5] = 1'b1;
        byte_op("R7 first write", 0, 0, 8'h22, 8'h00);
        byte_op("R7 held write", 0, 0, 8'hF0, 8'h00);

        // R9: byte write in the merge cycle wins.
        byte_op("R9 setup", 0, 1, 8'h24, 8'h00);
        bit_valid = 1; bit_we = 1; bit_addr = 8'h20; bit_wval = 1;
        @(posedge clk); @(negedge clk);
        bit_valid = 0; bit_we = 0;
        byte_valid = 1; byte_we = 1; byte_ind = 0; byte_addr = 8'h24; byte_wdata = 8'hA4;
        @(posedge clk); @(negedge clk);
        byte_valid = 0; byte_we = 0;
        exp_mem[8'h24] = 8'hA4;
        byte_op("R9 byte wins", 0, 0, 8'h24, 8'h00);

        // R10: byte write in the capture cycle is forwarded.
        bit_valid = 1; bit_we = 1; bit_addr = 8'h09; bit_wval = 1;
        byte_valid = 1; byte_we = 1; byte_ind = 1; byte_addr = 8'h21; byte_wdata = 8'h40;
        @(posedge clk); @(negedge clk);
        bit_valid = 0; bit_we = 0; byte_valid = 0; byte_we = 0; byte_ind = 0;
        @(posedge clk); @(negedge clk);
        exp_mem[8'h21] = 8'h42;
        byte_op("R10 forwarded merge", 0, 0, 8'h21, 8'h00);

        // Constrained random mix.
        for (int n = 0; n < 800; n++) begin
            logic [7:0] a, d;
            int op;
            op = int'($urandom % 6);
            a = 8'($urandom);
            d = 8'($urandom);
            case (op)
                0: byte_op("R2", 0, 1, a, d);
                1: byte_op("R2", 0, 0, a, 8'h00);
                2: byte_op(a[7] ? "R4" : "R3", 1, d[0], a, d);
                3: bit_wr(a, d[0]);
                4: bit_rd(a);
                default: byte_op("R3", 1, 0, {1'b0, a[6:0]}, 8'h00);
            endcase
        end
        for (int i = 0; i < 256; i++) byte_op("R7 final image", 0, 0, 8'(i), 8'h00);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule